// File: doc/BRIEF.md
# Reference-Calibrated ADC Channel Controller

This block sits in front of a sixteen-input housekeeping converter and turns a channel request into a corrected reading in signed millivolts. Every channel has its own stored settings: an oversampling ratio that trades measurement time against quality, a flag selecting absolute or ratiometric correction, and a reference-pair code used in ratiometric mode. A client asks for one channel at a time. The block drives a simple start/done port towards the converter and answers with a single-cycle result pulse.

In absolute mode the reading is corrected with a straight line through two fixed reference inputs. Channel 12 is known to be 625 mV and channel 13 is known to be 1250 mV. Their raw codes are captured lazily: the first request after reset converts both references before the target channel. Every request after a recalibrate pulse does the same. The correction uses a multi-cycle serial divider. In ratiometric mode the converter is told which reference pair to use, and the raw code is returned unchanged.

Top module: `refcal_adc_ctrl`

## Requirements
- R1: After reset, `busy`, `rsp_valid` and `cnv_start` are low. Every channel starts with ratio 512, absolute mode and reference code 0.
- R2: The first accepted request after reset converts channel 12 and then channel 13, each at ratio code 0 with `cnv_ratiometric` low and `cnv_refsel` 0, before it converts the requested channel.
- R3: Later requests reuse the stored reference codes and launch exactly one conversion. A `recal` pulse makes the next accepted request convert channels 12 and 13 again first.
- R4: In absolute mode the result is 625 + (raw − lo) × 625 / (hi − lo), rounded toward zero, where lo and hi are the stored codes of channels 12 and 13.
- R5: If hi equals lo, an absolute-mode request answers with `rsp_err` high and `rsp_mv` zero.
- R6: The ratio values 512, 1024, 2048 and 4096 appear on `cnv_dec` as 0, 1, 2 and 3 for the requested channel's conversion.
- R7: A request for a channel whose stored ratio is any other value is answered in the cycle after acceptance with `rsp_err` high and `rsp_mv` zero. No conversion is started.
- R8: In ratiometric mode the conversion carries `cnv_ratiometric` high and the stored code on `cnv_refsel`, and the result is the raw code zero-extended. The valid codes are 0 (crystal input/ground), 1 (PMIC input/ground), 2 (PMIC input/current-sense), 4 (ground/ground) and 5 (reference/ground). Any other code, including 3, is refused as in R7.
- R9: `busy` is high from acceptance until the result. `rsp_valid` is high in the cycle `busy` falls. Requests made while `busy` is high are ignored. `rsp_err` is high only with `rsp_valid` and then `rsp_mv` is zero.
- R10: `cnv_start` is a one-cycle pulse that occurs only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recal | input | 1 | Marks the stored reference codes stale |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 4 | Channel being configured |
| cfg_ratio | input | 13 | Oversampling ratio value |
| cfg_ratiometric | input | 1 | 1 selects ratiometric mode |
| cfg_refsel | input | 3 | Reference-pair code |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_chan | input | 4 | Requested channel |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_err | output | 1 | Result is an error |
| rsp_mv | output | 24 | Signed result |
| cnv_start | output | 1 | Conversion start pulse |
| cnv_chan | output | 4 | Channel to convert |
| cnv_dec | output | 2 | Ratio code, 0 = 512 up to 3 = 4096 |
| cnv_ratiometric | output | 1 | Use the reference pair |
| cnv_refsel | output | 3 | Reference-pair code |
| cnv_done | input | 1 | Conversion finished |
| cnv_code | input | 12 | Raw conversion code |

## Verification
Directed requests place readings above, below and exactly on the reference codes. This separates a correct signed interpolation, with truncation toward zero on negative offsets, from an unsigned or floor-rounded one. One reference code is changed without a recalibrate pulse and then with one, which shows whether stale codes are reused and whether the refresh happens. Configuration patterns cover all four ratios, an unlisted ratio, every reference-pair code in ratiometric mode, and equal reference codes. Together they exercise the refusal paths and the zero-divisor path. Randomly seeded sequences then mix writes, recalibrations, reference drift and requests, some with extra requests held during busy, and compare against a bench model.

// File: rtl/refcal_pkg.sv
package refcal_pkg;

    localparam int RATIO_W = 13;
    localparam int DEC_W   = 2;
    localparam int REF_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAL_LO,
        ST_CAL_HI,
        ST_MEAS,
        ST_DIV
    } ctrl_state_e;

    typedef struct packed {
        logic             ok;
        logic [DEC_W-1:0] sel;
    } dec_map_t;

    // Only the four power-of-two ratios are accepted.
    function automatic dec_map_t map_ratio(input logic [RATIO_W-1:0] r);
        dec_map_t m;
        m = '{ok: 1'b1, sel: '0};
        case (r)
            RATIO_W'(512):  m.sel = 2'd0;
            RATIO_W'(1024): m.sel = 2'd1;
            RATIO_W'(2048): m.sel = 2'd2;
            RATIO_W'(4096): m.sel = 2'd3;
            default:        m.ok  = 1'b0;
        endcase
        return m;
    endfunction

    // Reference-pair codes 0,1,2,4,5 are defined; the rest are refused.
    function automatic logic ref_code_ok(input logic [REF_W-1:0] c);
        return (c <= REF_W'(5)) && (c != REF_W'(3));
    endfunction

endpackage

// File: rtl/refcal_cfg_store.sv
module refcal_cfg_store
    import refcal_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CH_W-1:0]    wr_chan,
    input  logic [RATIO_W-1:0] wr_ratio,
    input  logic               wr_ratiom,
    input  logic [REF_W-1:0]   wr_ref,
    input  logic [CH_W-1:0]    rd_chan,
    output logic [RATIO_W-1:0] rd_ratio,
    output logic               rd_ratiom,
    output logic [REF_W-1:0]   rd_ref
);

    logic [RATIO_W-1:0] ratio_q  [NCH];
    logic               ratiom_q [NCH];
    logic [REF_W-1:0]   ref_q    [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ratio_q[g]  <= RATIO_W'(512);
                ratiom_q[g] <= 1'b0;
                ref_q[g]    <= '0;
            end else if (wr_en && (wr_chan == CH_W'(g))) begin
                ratio_q[g]  <= wr_ratio;
                ratiom_q[g] <= wr_ratiom;
                ref_q[g]    <= wr_ref;
            end
        end
    end

    assign rd_ratio  = ratio_q[rd_chan];
    assign rd_ratiom = ratiom_q[rd_chan];
    assign rd_ref    = ref_q[rd_chan];

endmodule

// File: rtl/refcal_div.sv
module refcal_div #(
    parameter int NW = 22,
    parameter int DW = 13,
    localparam int CW = $clog2(NW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          done,
    output logic [NW-1:0] quo
);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [DW-1:0] rem;
        logic [NW-1:0] quo;
        logic [DW-1:0] den;
        logic          done;
    } div_t;

    div_t q, d;
    logic [DW:0] trial;

    always_comb begin
        d     = q;
        d.done = 1'b0;
        trial = {q.rem, q.quo[NW-1]};
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = CW'(NW);
            d.rem  = '0;
            d.quo  = num;
            d.den  = den;
        end else if (q.busy) begin
            if (trial >= {1'b0, q.den}) begin
                d.rem = DW'(trial - {1'b0, q.den});
                d.quo = {q.quo[NW-2:0], 1'b1};
            end else begin
                d.rem = trial[DW-1:0];
                d.quo = {q.quo[NW-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
    assign quo  = q.quo;

endmodule

// File: rtl/refcal_adc_ctrl.sv
module refcal_adc_ctrl
    import refcal_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int RAW_W = 12,
    parameter int OUT_W = 24,
    parameter int CH_LO = 12,
    parameter int CH_HI = 13,
    parameter int MV_LO = 625,
    parameter int MV_HI = 1250,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    recal,
    input  logic                    cfg_we,
    input  logic [CH_W-1:0]         cfg_chan,
    input  logic [RATIO_W-1:0]      cfg_ratio,
    input  logic                    cfg_ratiometric,
    input  logic [REF_W-1:0]        cfg_refsel,
    input  logic                    req_valid,
    input  logic [CH_W-1:0]         req_chan,
    output logic                    busy,
    output logic                    rsp_valid,
    output logic                    rsp_err,
    output logic signed [OUT_W-1:0] rsp_mv,
    output logic                    cnv_start,
    output logic [CH_W-1:0]         cnv_chan,
    output logic [DEC_W-1:0]        cnv_dec,
    output logic                    cnv_ratiometric,
    output logic [REF_W-1:0]        cnv_refsel,
    input  logic                    cnv_done,
    input  logic [RAW_W-1:0]        cnv_code
);

    localparam int MV_STEP = MV_HI - MV_LO;
    localparam int STEP_W  = $clog2(MV_STEP + 1);
    localparam int MAG_W   = RAW_W + STEP_W;

    typedef struct packed {
        ctrl_state_e       st;
        logic [CH_W-1:0]   chan;
        logic [DEC_W-1:0]  dec;
        logic              ratiom;
        logic [REF_W-1:0]  refsel;
        logic              stale;
        logic [RAW_W-1:0]  r_lo;
        logic [RAW_W-1:0]  r_hi;
        logic              neg;
        logic              cnv_start;
        logic [CH_W-1:0]   cnv_chan;
        logic [DEC_W-1:0]  cnv_dec;
        logic              cnv_rm;
        logic [REF_W-1:0]  cnv_ref;
        logic              rsp_valid;
        logic              rsp_err;
        logic [OUT_W-1:0]  rsp_mv;
    } regs_t;

    regs_t q, d;

    logic [RATIO_W-1:0] st_ratio;
    logic               st_ratiom;
    logic [REF_W-1:0]   st_ref;
    dec_map_t           rmap;

    logic signed [RAW_W:0] diff_s, den_s;
    logic [RAW_W:0]        diff_abs, den_abs;
    logic [MAG_W-1:0]      num_mag;
    logic                  div_start, div_done;
    logic [MAG_W-1:0]      div_quo;

    refcal_cfg_store #(.NCH(NCH)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_chan   (cfg_chan),
        .wr_ratio  (cfg_ratio),
        .wr_ratiom (cfg_ratiometric),
        .wr_ref    (cfg_refsel),
        .rd_chan   (req_chan),
        .rd_ratio  (st_ratio),
        .rd_ratiom (st_ratiom),
        .rd_ref    (st_ref)
    );

    refcal_div #(.NW(MAG_W), .DW(RAW_W + 1)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (num_mag),
        .den   (den_abs),
        .done  (div_done),
        .quo   (div_quo)
    );

    // Signed offset of the reading and span of the references.
    assign diff_s   = $signed({1'b0, cnv_code}) - $signed({1'b0, q.r_lo});
    assign den_s    = $signed({1'b0, q.r_hi})   - $signed({1'b0, q.r_lo});
    assign diff_abs = diff_s[RAW_W] ? (~diff_s + 1'b1) : diff_s;
    assign den_abs  = den_s[RAW_W]  ? (~den_s + 1'b1)  : den_s;
    assign num_mag  = MAG_W'(diff_abs) * MAG_W'(MV_STEP);
    assign rmap     = map_ratio(st_ratio);

    function automatic regs_t launch(input regs_t r, input logic [CH_W-1:0] ch,
                                     input logic [DEC_W-1:0] dc, input logic rm,
                                     input logic [REF_W-1:0] rf);
        regs_t o;
        o           = r;
        o.cnv_start = 1'b1;
        o.cnv_chan  = ch;
        o.cnv_dec   = dc;
        o.cnv_rm    = rm;
        o.cnv_ref   = rf;
        return o;
    endfunction

    always_comb begin
        d           = q;
        d.cnv_start = 1'b0;
        d.rsp_valid = 1'b0;
        d.rsp_err   = 1'b0;
        div_start   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!rmap.ok || (st_ratiom && !ref_code_ok(st_ref))) begin
                        d.rsp_valid = 1'b1;
                        d.rsp_err   = 1'b1;
                        d.rsp_mv    = '0;
                    end else begin
                        d.chan   = req_chan;
                        d.dec    = rmap.sel;
                        d.ratiom = st_ratiom;
                        d.refsel = st_ref;
                        if (q.stale) begin
                            d    = launch(d, CH_W'(CH_LO), '0, 1'b0, '0);
                            d.st = ST_CAL_LO;
                        end else begin
                            d    = launch(d, req_chan, rmap.sel, st_ratiom, st_ref);
                            d.st = ST_MEAS;
                        end
                    end
                end
            end
            ST_CAL_LO: begin
                if (cnv_done) begin
                    d.r_lo = cnv_code;
                    d      = launch(d, CH_W'(CH_HI), '0, 1'b0, '0);
                    d.st   = ST_CAL_HI;
                end
            end
            ST_CAL_HI: begin
                if (cnv_done) begin
                    d.r_hi  = cnv_code;
                    d.stale = 1'b0;
                    d       = launch(d, q.chan, q.dec, q.ratiom, q.refsel);
                    d.st    = ST_MEAS;
                end
            end
            ST_MEAS: begin
                if (cnv_done) begin
                    if (q.ratiom) begin
                        d.rsp_valid = 1'b1;
                        d.rsp_mv    = OUT_W'(cnv_code);
                        d.st        = ST_IDLE;
                    end else if (den_s == '0) begin
                        d.rsp_valid = 1'b1;
                        d.rsp_err   = 1'b1;
                        d.rsp_mv    = '0;
                        d.st        = ST_IDLE;
                    end else begin
                        div_start = 1'b1;
                        d.neg     = diff_s[RAW_W] ^ den_s[RAW_W];
                        d.st      = ST_DIV;
                    end
                end
            end
            ST_DIV: begin
                if (div_done) begin
                    d.rsp_valid = 1'b1;
                    d.rsp_mv    = OUT_W'(MV_LO) +
                                  (q.neg ? (~OUT_W'(div_quo) + 1'b1) : OUT_W'(div_quo));
                    d.st        = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (recal) d.stale = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.stale <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy            = (q.st != ST_IDLE);
    assign rsp_valid       = q.rsp_valid;
    assign rsp_err         = q.rsp_err;
    assign rsp_mv          = $signed(q.rsp_mv);
    assign cnv_start       = q.cnv_start;
    assign cnv_chan        = q.cnv_chan;
    assign cnv_dec         = q.cnv_dec;
    assign cnv_ratiometric = q.cnv_rm;
    assign cnv_refsel      = q.cnv_ref;

endmodule

// File: rtl/refcal_adc_ctrl_chk.sv
module refcal_adc_ctrl_chk #(
    parameter int OUT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic [OUT_W-1:0] rsp_mv,
    input logic             cnv_start
);

    assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> !cnv_start);

    assert_start_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |-> busy);

    assert_accept_launches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cnv_start);

    assert_result_on_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rsp_valid);

    assert_err_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && (rsp_mv == '0)));

    assert_refuse_no_conv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err && !$past(busy)) |-> (!cnv_start && !busy));

endmodule

bind refcal_adc_ctrl refcal_adc_ctrl_chk #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_mv    (rsp_mv),
    .cnv_start (cnv_start)
);

// File: tb/refcal_adc_ctrl_test.sv
module refcal_adc_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic recal = 1'b0;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_chan = '0;
    logic [12:0] cfg_ratio = '0;
    logic cfg_ratiometric = 1'b0;
    logic [2:0] cfg_refsel = '0;
    logic req_valid = 1'b0;
    logic [3:0] req_chan = '0;
    logic busy, rsp_valid, rsp_err, cnv_start, cnv_ratiometric;
    logic signed [23:0] rsp_mv;
    logic [3:0] cnv_chan;
    logic [1:0] cnv_dec;
    logic [2:0] cnv_refsel;
    logic cnv_done = 1'b0;
    logic [11:0] cnv_code = '0;

    always #2 clk = ~clk;

    refcal_adc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .recal(recal),
        .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_ratio(cfg_ratio),
        .cfg_ratiometric(cfg_ratiometric), .cfg_refsel(cfg_refsel),
        .req_valid(req_valid), .req_chan(req_chan), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_mv(rsp_mv),
        .cnv_start(cnv_start), .cnv_chan(cnv_chan), .cnv_dec(cnv_dec),
        .cnv_ratiometric(cnv_ratiometric), .cnv_refsel(cnv_refsel),
        .cnv_done(cnv_done), .cnv_code(cnv_code)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    // Converter stub: latency grows with the ratio code.
    logic [11:0] raw_tab [16];
    int  log_n = 0;
    int  log_ch [8];
    int  log_dec [8];
    int  log_rm [8];
    int  log_ref [8];
    bit  pend = 0;
    int  lat = 0;
    int  pch = 0;

    always @(negedge clk) begin
        cnv_done = 1'b0;
        if (pend) begin
            if (lat == 0) begin
                cnv_done = 1'b1;
                cnv_code = raw_tab[pch];
                pend = 0;
            end else lat--;
        end
        if (rst_n && cnv_start) begin
            if (log_n < 8) begin
                log_ch[log_n]  = int'(cnv_chan);
                log_dec[log_n] = int'(cnv_dec);
                log_rm[log_n]  = int'(cnv_ratiometric);
                log_ref[log_n] = int'(cnv_refsel);
            end
            log_n++;
            pend = 1;
            pch  = int'(cnv_chan);
            lat  = 1 << cnv_dec;
        end
    end

    // Bench model of the configuration and calibration state.
    int m_ratio [16];
    int m_rm [16];
    int m_ref [16];
    bit m_stale = 1;
    int m_lo = 0;
    int m_hi = 0;

    function automatic int dec_of(input int r);
        case (r)
            512: return 0;
            1024: return 1;
            2048: return 2;
            4096: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic bit ref_ok(input int c);
        return (c <= 5) && (c != 3);
    endfunction

    function automatic int exp_mv(input int raw, input int lo, input int hi);
        return 625 + ((raw - lo) * 625) / (hi - lo);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int ch, input int ratio, input int rm, input int rf);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = 4'(ch); cfg_ratio = 13'(ratio);
        cfg_ratiometric = rm[0]; cfg_refsel = 3'(rf);
        @(negedge clk);
        cfg_we = 1'b0;
        m_ratio[ch] = ratio % 8192; m_rm[ch] = rm; m_ref[ch] = rf;
    endtask

    task automatic pulse_recal();
        @(negedge clk);
        recal = 1'b1;
        @(negedge clk);
        recal = 1'b0;
        m_stale = 1;
    endtask

    task automatic do_req(input int ch, input bit extra);
        bit ok, stale_now;
        int e_err, e_val, e_n, wait_n;
        string vtag;
        ok = (dec_of(m_ratio[ch]) >= 0) && (!m_rm[ch] || ref_ok(m_ref[ch]));
        stale_now = m_stale;
        vtag = m_rm[ch] ? "R8" : "R4";
        e_err = 0; e_val = 0; e_n = 0;
        if (!ok) begin
            e_err = 1;
            e_n = 0;
            vtag = (dec_of(m_ratio[ch]) < 0) ? "R7" : "R8";
        end else begin
            if (m_stale) begin
                m_lo = int'(raw_tab[12]);
                m_hi = int'(raw_tab[13]);
                m_stale = 0;
            end
            e_n = stale_now ? 3 : 1;
            if (m_rm[ch]) e_val = int'(raw_tab[ch]);
            else if (m_hi == m_lo) begin e_err = 1; vtag = "R5"; end
            else e_val = exp_mv(int'(raw_tab[ch]), m_lo, m_hi);
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        log_n = 0;
        req_valid = 1'b1; req_chan = 4'(ch);
        @(negedge clk);
        req_valid = 1'b0;
        if (extra && ok) begin
            req_valid = 1'b1; req_chan = 4'(ch ^ 1);
            check(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
        end
        wait_n = 0;
        while (!rsp_valid && wait_n < 2000) begin
            @(negedge clk);
            wait_n++;
        end
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, "R9", "response seen", int'(rsp_valid), 1);
        if (!ok) check(wait_n == 0, "R7", "refusal latency", wait_n, 0);
        check(int'(rsp_err) == e_err, vtag, "rsp_err", int'(rsp_err), e_err);
        check(int'(rsp_mv) == e_val, vtag, "rsp_mv", int'(rsp_mv), e_val);
        check(log_n == e_n, stale_now ? "R2" : "R3", "conversion count", log_n, e_n);
        if (ok && log_n == e_n) begin
            if (stale_now) begin
                check(log_ch[0] == 12 && log_dec[0] == 0 && log_rm[0] == 0 && log_ref[0] == 0,
                      "R2", "first ref conversion channel", log_ch[0], 12);
                check(log_ch[1] == 13 && log_dec[1] == 0 && log_rm[1] == 0 && log_ref[1] == 0,
                      "R2", "second ref conversion channel", log_ch[1], 13);
            end
            check(log_ch[e_n-1] == ch, "R2", "target channel", log_ch[e_n-1], ch);
            check(log_dec[e_n-1] == dec_of(m_ratio[ch]), "R6", "ratio code",
                  log_dec[e_n-1], dec_of(m_ratio[ch]));
            check(log_rm[e_n-1] == m_rm[ch], "R8", "ratiometric flag", log_rm[e_n-1], m_rm[ch]);
            if (m_rm[ch] != 0)
                check(log_ref[e_n-1] == m_ref[ch], "R8", "ref code", log_ref[e_n-1], m_ref[ch]);
        end
        @(negedge clk);
        check(rsp_valid == 1'b0 || !ok, "R9", "single-cycle pulse", int'(rsp_valid), 0);
        if (extra && ok) begin
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (rsp_valid || busy) begin
                    check(1'b0, "R9", "request during busy was served", 1, 0);
                    break;
                end
            end
            check(log_n == e_n, "R9", "no extra conversions", log_n, e_n);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7351));
        for (int i = 0; i < 16; i++) begin
            raw_tab[i] = 12'(100 + i * 200);
            m_ratio[i] = 512; m_rm[i] = 0; m_ref[i] = 0;
        end
        raw_tab[12] = 12'd1000; raw_tab[13] = 12'd2000;
        raw_tab[14] = 12'd520;  raw_tab[15] = 12'd0;
        raw_tab[5] = 12'd1500;  raw_tab[7] = 12'd300;
        repeat (3) @(negedge clk);
        check(!busy && !rsp_valid && !cnv_start, "R1", "outputs in reset",
              int'(busy) + int'(rsp_valid) + int'(cnv_start), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !rsp_valid && !cnv_start, "R1", "outputs after reset",
              int'(busy) + int'(rsp_valid) + int'(cnv_start), 0);

        do_req(5, 0);                 // R2 first calibration, R4 937
        do_req(7, 0);                 // R4 negative offset -> 188, R3 one conversion
        do_req(15, 0);                // mux-off input below both references
        raw_tab[12] = 12'd1100;
        do_req(5, 0);                 // R3 stale codes still used
        pulse_recal();
        do_req(5, 0);                 // R3 refresh -> 902
        do_req(12, 0);                // reference channel itself -> 625
        cfg_write(3, 4096, 0, 0); do_req(3, 0);   // R6 code 3
        cfg_write(4, 1024, 0, 0); do_req(4, 0);   // R6 code 1
        cfg_write(6, 2048, 0, 0); do_req(6, 0);   // R6 code 2
        cfg_write(9, 700, 0, 0);  do_req(9, 0);   // R7 bad ratio
        cfg_write(9, 0, 0, 0);    do_req(9, 0);   // R7 zero ratio
        raw_tab[10] = 12'd3333;
        for (int c = 0; c < 8; c++) begin
            cfg_write(10, 512, 1, c); do_req(10, 0); // R8 every code
        end
        cfg_write(10, 512, 0, 3); do_req(10, 0);  // code 3 ignored in absolute mode
        raw_tab[12] = 12'd800; raw_tab[13] = 12'd800;
        pulse_recal();
        do_req(2, 0);                 // R5 zero span
        cfg_write(11, 1024, 1, 4); do_req(11, 0); // R8 unaffected by zero span
        raw_tab[13] = 12'd700;
        pulse_recal();
        do_req(8, 0);                 // negative span
        raw_tab[12] = 12'd1000; raw_tab[13] = 12'd2000;
        pulse_recal();
        do_req(5, 1);                 // R9 requests during busy ignored

        for (int it = 0; it < 120; it++) begin
            int op;
            op = int'($urandom % 10);
            if (op == 0) begin
                int sel, ch;
                sel = int'($urandom % 5);
                ch = int'($urandom % 16);
                cfg_write(ch, (sel < 4) ? (512 << sel) : int'($urandom % 8192),
                          ($urandom % 3 == 0) ? 1 : 0, int'($urandom % 8));
            end else if (op == 1) begin
                pulse_recal();
            end else if (op == 2) begin
                int rc;
                rc = 12 + int'($urandom % 2);
                raw_tab[rc] = 12'($urandom % 4096);
                if ($urandom % 8 == 0) raw_tab[25 - rc] = raw_tab[rc];
            end else begin
                int ch;
                ch = int'($urandom % 16);
                raw_tab[ch < 12 ? ch : 0] = 12'($urandom % 4096);
                do_req(ch, ($urandom % 4) == 0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule